// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block produces the address phase of a NAND flash access. Given a column address, a page address, a page-size select and a 2-bit length code, it puts the address bytes on a byte-wide bus one at a time. Each byte is marked by an address-latch strobe. A request can ask for column bytes only, page bytes only, or column bytes followed by page bytes. The number of column bytes follows the page-size select. The number of page bytes follows the length code. A combined request therefore issues between three and six bytes.

A request starts with a one-cycle `start` pulse while the block is idle. The block captures all request inputs in that cycle, raises `busy`, and steps through the bytes. It holds each strobe for a programmed number of clocks and leaves a one-clock gap after it. It ends with a one-cycle `done` pulse. A page request that uses the reserved length code is refused: no byte goes out, and `done` and `err` pulse together. Command cycles and data transfer belong to neighbouring logic.

Top module: `nand_addr_seq`

## Requirements
- R1: `wide_page`=0 gives one column byte. `wide_page`=1 gives two column bytes. Column bytes go out least-significant first: `col_addr[7:0]` and then `col_addr[15:8]`.
- R2: `len_code` sets the number of page bytes: 2'b00 gives two, 2'b01 gives three, 2'b10 gives four. Page bytes go out least-significant first, starting at `page_addr[7:0]`.
- R3: When both `want_col` and `want_page` are 1, every column byte goes out before the first page byte. The total is 3 to 6 bytes, the sum of the two counts.
- R4: When `want_page`=1 and `len_code`=2'b11 (reserved), no strobe is issued. `done` and `err` are both high for exactly one cycle, in the cycle after `start` is accepted. With `want_page`=0, the code 2'b11 has no effect.
- R5: `nand_ale` stays high for H consecutive clocks per byte. H is `hold_cfg`, and a value of 0 counts as 1. `nand_io` does not change while `nand_ale` is high.
- R6: Between two bytes of one request, `nand_ale` is low for exactly one clock.
- R7: `busy` rises in the cycle after `start` is accepted and falls when `done` pulses. `done` is high for one cycle, N*(H+1) clocks after the first strobe cycle, where N is the byte count.
- R8: While `busy` is high, `start` is ignored and changes on the request inputs have no effect. The bytes already captured go out, and no second request follows.
- R9: A request with `want_col`=0 and `want_page`=0 issues no strobe. `done` pulses in the cycle after acceptance, and `err` stays low.
- R10: After reset, `busy`, `done`, `err` and `nand_ale` are 0 and `nand_io` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| want_col | input | 1 | Issue column bytes |
| want_page | input | 1 | Issue page bytes |
| wide_page | input | 1 | Page-size select: 0 gives one column byte, 1 gives two |
| len_code | input | 2 | Page byte count code (00, 01, 10; 11 reserved) |
| hold_cfg | input | HOLD_W | Strobe hold length in clocks (0 counts as 1) |
| col_addr | input | 2*BYTE_W | Column address |
| page_addr | input | 4*BYTE_W | Page address |
| nand_ale | output | 1 | Address-latch strobe |
| nand_io | output | BYTE_W | Address byte on the flash bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle reserved-code pulse, paired with done |

## Verification
The bench builds the block with `BYTE_W`=8 and `HOLD_W`=2. This makes every hold setting (0 to 3) cheap enough to sweep in full. It crosses the hold settings with all four request shapes, both page sizes and all four length codes, including the reserved one. Every byte count from 0 to 6 is therefore reached, as is every order of column and page bytes and the error path. On each request that issues bytes, the bench pulses a second `start` and scrambles the inputs partway through, to show that a running sequence is not disturbed.

// File: rtl/nand_addr_pkg.sv
package nand_addr_pkg;

    localparam int COL_BYTES_MAX  = 2;
    localparam int PAGE_BYTES_MAX = 4;
    localparam int SEQ_BYTES_MAX  = COL_BYTES_MAX + PAGE_BYTES_MAX;
    localparam int CNT_W          = $clog2(SEQ_BYTES_MAX + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        LEN_TWO   = 2'b00,
        LEN_THREE = 2'b01,
        LEN_FOUR  = 2'b10,
        LEN_RSVD  = 2'b11
    } len_code_t;

    typedef struct packed {
        logic [CNT_W-1:0] col_n;
        logic [CNT_W-1:0] total;
        logic             bad;
    } req_plan_t;

    function automatic logic [CNT_W-1:0] col_count(input logic wide);
        return wide ? CNT_W'(2) : CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] page_count(input len_code_t code);
        case (code)
            LEN_TWO:   return CNT_W'(2);
            LEN_THREE: return CNT_W'(3);
            LEN_FOUR:  return CNT_W'(4);
            default:   return CNT_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
    import nand_addr_pkg::*;
(
    input  logic      want_col,
    input  logic      want_page,
    input  logic      wide,
    input  logic [1:0] len_code,
    output req_plan_t plan_o
);

    len_code_t        code;
    logic [CNT_W-1:0] cn;
    logic [CNT_W-1:0] pn;

    assign code = len_code_t'(len_code);

    always_comb begin
        plan_o.bad = want_page && (code == LEN_RSVD);
        cn = want_col  ? col_count(wide)  : '0;
        pn = want_page ? page_count(code) : '0;
        if (plan_o.bad) begin
            plan_o.col_n = '0;
            plan_o.total = '0;
        end else begin
            plan_o.col_n = cn;
            plan_o.total = cn + pn;
        end
    end

endmodule

// File: rtl/nand_addr_bytesel.sv
module nand_addr_bytesel
    import nand_addr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [COL_BYTES_MAX*BYTE_W-1:0]  col_v,
    input  logic [PAGE_BYTES_MAX*BYTE_W-1:0] page_v,
    input  logic [CNT_W-1:0]                 col_n,
    input  logic [CNT_W-1:0]                 pick,
    output logic [BYTE_W-1:0]                byte_o
);

    logic [BYTE_W-1:0] col_pad  [SEQ_BYTES_MAX];
    logic [BYTE_W-1:0] page_pad [SEQ_BYTES_MAX];
    logic [BYTE_W-1:0] slot     [SEQ_BYTES_MAX];

    for (genvar k = 0; k < SEQ_BYTES_MAX; k++) begin : g_slot
        if (k < COL_BYTES_MAX) begin : g_col
            assign col_pad[k] = col_v[k*BYTE_W +: BYTE_W];
        end else begin : g_col_zero
            assign col_pad[k] = '0;
        end
        if (k < PAGE_BYTES_MAX) begin : g_page
            assign page_pad[k] = page_v[k*BYTE_W +: BYTE_W];
        end else begin : g_page_zero
            assign page_pad[k] = '0;
        end
        always_comb begin
            if (CNT_W'(k) < col_n) begin
                slot[k] = col_pad[k];
            end else begin
                slot[k] = page_pad[CNT_W'(k) - col_n];
            end
        end
    end

    always_comb begin
        if (pick < CNT_W'(SEQ_BYTES_MAX)) begin
            byte_o = slot[pick];
        end else begin
            byte_o = '0;
        end
    end

endmodule

// File: rtl/nand_addr_hold.sv
module nand_addr_hold #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expire
);

    logic [HOLD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? HOLD_W'(1) : load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - HOLD_W'(1);
        end
    end

    assign expire = (cnt == HOLD_W'(1));

endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nand_addr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HOLD_W = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             want_col,
    input  logic                             want_page,
    input  logic                             wide_page,
    input  logic [1:0]                       len_code,
    input  logic [HOLD_W-1:0]                hold_cfg,
    input  logic [COL_BYTES_MAX*BYTE_W-1:0]  col_addr,
    input  logic [PAGE_BYTES_MAX*BYTE_W-1:0] page_addr,
    output logic                             nand_ale,
    output logic [BYTE_W-1:0]                nand_io,
    output logic                             busy,
    output logic                             done,
    output logic                             err
);

    localparam int COL_W  = COL_BYTES_MAX * BYTE_W;
    localparam int PAGE_W = PAGE_BYTES_MAX * BYTE_W;

    seq_state_t        state;
    req_plan_t         plan_in;
    logic [CNT_W-1:0]  col_n_q;
    logic [CNT_W-1:0]  total_q;
    logic [COL_W-1:0]  col_q;
    logic [PAGE_W-1:0] page_q;
    logic [HOLD_W-1:0] hold_q;
    logic [CNT_W-1:0]  idx;

    logic              idle;
    logic              last;
    logic [COL_W-1:0]  col_src;
    logic [PAGE_W-1:0] page_src;
    logic [CNT_W-1:0]  col_n_src;
    logic [CNT_W-1:0]  idx_nxt;
    logic [BYTE_W-1:0] byte_sel;
    logic              launch;
    logic              tmr_load;
    logic [HOLD_W-1:0] tmr_val;
    logic              tmr_expire;

    nand_addr_plan u_plan (
        .want_col  (want_col),
        .want_page (want_page),
        .wide      (wide_page),
        .len_code  (len_code),
        .plan_o    (plan_in)
    );

    // In idle the first byte comes from the live inputs; afterwards from the capture.
    assign idle      = (state == ST_IDLE);
    assign col_src   = idle ? col_addr      : col_q;
    assign page_src  = idle ? page_addr     : page_q;
    assign col_n_src = idle ? plan_in.col_n : col_n_q;
    assign idx_nxt   = idle ? '0            : idx + CNT_W'(1);
    assign last      = (idx == total_q - CNT_W'(1));

    nand_addr_bytesel #(.BYTE_W(BYTE_W)) u_sel (
        .col_v  (col_src),
        .page_v (page_src),
        .col_n  (col_n_src),
        .pick   (idx_nxt),
        .byte_o (byte_sel)
    );

    assign launch   = idle && start && (plan_in.total != '0);
    assign tmr_load = launch || ((state == ST_GAP) && !last);
    assign tmr_val  = idle ? hold_cfg : hold_q;

    nand_addr_hold #(.HOLD_W(HOLD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            col_n_q  <= '0;
            total_q  <= '0;
            col_q    <= '0;
            page_q   <= '0;
            hold_q   <= '0;
            idx      <= '0;
            nand_ale <= 1'b0;
            nand_io  <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (plan_in.total == '0) begin
                            done <= 1'b1;
                            err  <= plan_in.bad;
                        end else begin
                            col_n_q  <= plan_in.col_n;
                            total_q  <= plan_in.total;
                            col_q    <= col_addr;
                            page_q   <= page_addr;
                            hold_q   <= hold_cfg;
                            idx      <= '0;
                            nand_ale <= 1'b1;
                            nand_io  <= byte_sel;
                            busy     <= 1'b1;
                            state    <= ST_STROBE;
                        end
                    end
                end
                ST_STROBE: begin
                    if (tmr_expire) begin
                        nand_ale <= 1'b0;
                        state    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (last) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        nand_io <= '0;
                        state   <= ST_IDLE;
                    end else begin
                        idx      <= idx_nxt;
                        nand_ale <= 1'b1;
                        nand_io  <= byte_sel;
                        state    <= ST_STROBE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nand_addr_seq_chk.sv
module nand_addr_seq_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              nand_ale,
    input logic [BYTE_W-1:0] nand_io,
    input logic              busy,
    input logic              done,
    input logic              err
);

    assert_bus_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (nand_ale && $past(nand_ale)) |-> $stable(nand_io));

    assert_one_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !nand_ale) |=> (nand_ale || done));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
        nand_ale |-> busy);

endmodule

bind nand_addr_seq nand_addr_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .nand_ale (nand_ale),
    .nand_io  (nand_io),
    .busy     (busy),
    .done     (done),
    .err      (err)
);

// File: tb/test_nand_addr_seq.sv
`timescale 1ns/1ps
module test_nand_addr_seq;

    localparam int BW = 8;
    localparam int HW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          want_col = 1'b0;
    logic          want_page = 1'b0;
    logic          wide_page = 1'b0;
    logic [1:0]    len_code = 2'b00;
    logic [HW-1:0] hold_cfg = '0;
    logic [15:0]   col_addr = '0;
    logic [31:0]   page_addr = '0;
    logic          nand_ale;
    logic [BW-1:0] nand_io;
    logic          busy;
    logic          done;
    logic          err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    nand_addr_seq #(.BYTE_W(BW), .HOLD_W(HW)) i_nand_addr_seq (
        .clk(clk), .rst(rst), .start(start), .want_col(want_col),
        .want_page(want_page), .wide_page(wide_page), .len_code(len_code),
        .hold_cfg(hold_cfg), .col_addr(col_addr), .page_addr(page_addr),
        .nand_ale(nand_ale), .nand_io(nand_io), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic wc, input logic wp, input logic wd,
                           input logic [1:0] lc, input logic [HW-1:0] hc,
                           input logic [15:0] ca, input logic [31:0] pa);
        int nc, np, n, heff, t, cap, runlen, gaplen, done_t;
        bit bad, err_seen, hold_ok, gap_ok, stab_ok, busy_ok, prev_ale;
        logic [7:0] expb [8];
        logic [7:0] got  [8];
        bad  = wp && (lc == 2'b11);
        nc   = (wc && !bad) ? (wd ? 2 : 1) : 0;
        np   = (wp && !bad) ? (lc + 2) : 0;
        n    = nc + np;
        heff = (hc == 0) ? 1 : int'(hc);
        for (int i = 0; i < 8; i++) begin
            expb[i] = 8'h00;
            got[i]  = 8'h00;
        end
        for (int i = 0; i < nc; i++) expb[i] = ca[8*i +: 8];
        for (int j = 0; j < np; j++) expb[nc + j] = pa[8*j +: 8];

        @(negedge clk);
        want_col = wc; want_page = wp; wide_page = wd; len_code = lc;
        hold_cfg = hc; col_addr = ca; page_addr = pa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble request inputs once the request has been taken
        col_addr = ~ca; page_addr = ~pa; wide_page = ~wd; len_code = ~lc; hold_cfg = ~hc;
        t = 1; cap = 0; runlen = 0; gaplen = 0; done_t = 0; prev_ale = 0;
        hold_ok = 1; gap_ok = 1; stab_ok = 1; busy_ok = 1; err_seen = 0;
        while (done_t == 0 && t < 200) begin
            if (nand_ale) begin
                if (!prev_ale) begin
                    if (cap > 0 && gaplen != 1) gap_ok = 0;
                    if (cap < 8) got[cap] = nand_io;
                    cap++;
                    runlen = 0;
                end else if (cap <= 8 && nand_io != got[cap-1]) begin
                    stab_ok = 0;
                end
                runlen++;
            end else begin
                if (prev_ale) begin
                    if (runlen != heff) hold_ok = 0;
                    gaplen = 0;
                end
                gaplen++;
            end
            if (done) begin
                done_t = t;
                err_seen = err;
                if (busy) busy_ok = 0;
            end else if (busy != (n > 0)) begin
                busy_ok = 0;
            end
            prev_ale = nand_ale;
            if (!done) begin
                @(negedge clk);
                t++;
                start = (t == 2 && n > 0);
            end
        end
        start = 1'b0;
        chk(err_seen == bad, "R4", "err pulse", err_seen, bad);
        chk(cap == n, (nc > 0 && np > 0) ? "R3" : ((n == 0) ? "R9" : "R2"), "byte count", cap, n);
        for (int i = 0; i < n && i < cap; i++)
            chk(got[i] == expb[i], (i < nc) ? "R1" : "R2", "byte value", got[i], expb[i]);
        if (n > 0) begin
            chk(hold_ok && stab_ok, "R5", "strobe hold/stable", runlen, heff);
            chk(gap_ok, "R6", "gap length", gaplen, 1);
        end
        chk(busy_ok, "R7", "busy window", busy, n > 0);
        chk(done_t == ((n > 0) ? n * (heff + 1) + 1 : 1), "R7", "done cycle", done_t,
            (n > 0) ? n * (heff + 1) + 1 : 1);
        @(negedge clk);
        chk(!busy && !nand_ale && !done, "R8", "no restart after run", {busy, nand_ale, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !err && !nand_ale && nand_io == '0, "R10", "reset state",
            {busy, done, err, nand_ale, nand_io}, 0);
        for (int h = 0; h < 4; h++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 2; w++)
                    for (int l = 0; l < 4; l++)
                        run_one(m[0], m[1], w[0], l[1:0], h[HW-1:0],
                                16'hA5C3 ^ 16'(h * 977 + m * 131 + l * 17 + w),
                                32'h1E2D_3C4B + 32'((h * 16 + m * 4 + l) * 32'h0103_0507 + w));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule